// File: doc/BRIEF.md
# Branch and Interrupt Next-PC Unit

This unit decides where a small in-order 32-bit core fetches next. In the execute step of each instruction it takes the decoded control-flow flags, the comparison code, two source operands, the computed target address and the sequential address, and presents one next-PC value. The program counter register sits outside the unit. That register loads `pc_next` only in cycles where `exec_en` is high, and it resets to address 0.

The unit also implements a single level of interrupt. A one-bit busy flag records that a handler is running. A saved-return register holds the address execution would have reached when the interrupt was taken. When an interrupt request is accepted, the output is forced to the fixed handler vector (4) and the would-be next address is saved. The return-from-interrupt flag sends execution back to the saved address and clears the busy flag. Nested interrupts are not supported.

All pins are plain control and data levels. There is no streaming handshake, because the unit produces one combinational answer per execute cycle.

Top module: `bpc_unit`

## Requirements
- R1: The candidate address is chosen by priority: the saved return address when `ret_flag` is high; otherwise the aligned target when `jmp_flag` is high; otherwise the aligned target when a conditional branch is taken; otherwise `seq_pc`.
- R2: Whenever the target is selected, its two low bits are forced to zero before use.
- R3: `cmp_code` selects the branch condition on `op_a`/`op_b` as follows: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal. Codes 010 and 011 are never taken.
- R4: A branch can be taken only while `br_flag` is high. With `br_flag` low, the comparison result has no effect on `pc_next`.
- R5: The busy flag is clear after reset and changes only in cycles with `exec_en` high. In such a cycle `ret_flag` clears it; otherwise `irq_req` sets it; otherwise it holds.
- R6: An interrupt is accepted when `irq_req` is high and the busy flag is clear. While an interrupt is accepted, `pc_next` is 4 regardless of the other inputs.
- R7: The saved return register resets to 0. It loads the candidate address at a clock edge where an interrupt is accepted and `exec_en` is high, and it holds its value at every other edge.
- R8: While the busy flag is set, `irq_req` has no effect on `pc_next`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| exec_en | input | 1 | Execute-step enable; state updates only when high |
| irq_req | input | 1 | Interrupt request level |
| br_flag | input | 1 | Instruction is a conditional branch |
| jmp_flag | input | 1 | Instruction is an unconditional jump |
| ret_flag | input | 1 | Instruction is a return from interrupt |
| cmp_code | input | 3 | Branch comparison selector |
| op_a | input | 32 | First source operand |
| op_b | input | 32 | Second source operand |
| tgt_addr | input | 32 | Computed jump/branch target |
| seq_pc | input | 32 | Address of the next sequential instruction |
| pc_next | output | 32 | Next program counter |

## Verification
The two internal state elements are visible only through `pc_next`. A wrong busy flag shows in the same cycle as a wrong answer to an interrupt request: the vector 4 appears where the candidate was expected, or the reverse. A corrupted saved-return register stays hidden until the next return instruction, which then jumps to the wrong address. For that reason the bench reads the saved address back through a return instruction after each change to it, and after stimuli that must not change it. The bench also probes the busy flag with a request while `exec_en` is low.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  localparam logic [2:0] CMP_EQ  = 3'b000;
  localparam logic [2:0] CMP_NE  = 3'b001;
  localparam logic [2:0] CMP_LT  = 3'b100;
  localparam logic [2:0] CMP_GE  = 3'b101;
  localparam logic [2:0] CMP_LTU = 3'b110;
  localparam logic [2:0] CMP_GEU = 3'b111;

  typedef enum logic [1:0] {
    PICK_SEQ = 2'd0,
    PICK_TGT = 2'd1,
    PICK_RET = 2'd2
  } pick_e;
endpackage

// File: rtl/bpc_cond.sv
module bpc_cond #(
  parameter int XLEN = 32
) (
  input  logic [2:0]      cmp_code,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  output logic            hit
);
  import bpc_pkg::*;

  logic [XLEN:0] diff;
  logic          eq, lt_s, lt_u;

  // one subtractor serves both orderings
  always_comb begin
    diff = {1'b0, op_a} - {1'b0, op_b};
    eq   = (op_a == op_b);
    lt_u = diff[XLEN];
    lt_s = (op_a[XLEN-1] != op_b[XLEN-1]) ? op_a[XLEN-1] : diff[XLEN];
  end

  always_comb begin
    unique case (cmp_code)
      CMP_EQ:  hit = eq;
      CMP_NE:  hit = !eq;
      CMP_LT:  hit = lt_s;
      CMP_GE:  hit = !lt_s;
      CMP_LTU: hit = lt_u;
      CMP_GEU: hit = !lt_u;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/bpc_select.sv
module bpc_select #(
  parameter int XLEN       = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic            ret_flag,
  input  logic            jmp_flag,
  input  logic            br_flag,
  input  logic            cond_hit,
  input  logic [XLEN-1:0] saved_pc,
  input  logic [XLEN-1:0] tgt_addr,
  input  logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] cand
);
  import bpc_pkg::*;

  logic [XLEN-1:0] tgt_aligned;
  pick_e           pick;

  genvar gi;
  generate
    for (gi = 0; gi < XLEN; gi++) begin : g_align
      if (gi < ALIGN_BITS) begin : g_zero
        assign tgt_aligned[gi] = 1'b0;
      end else begin : g_keep
        assign tgt_aligned[gi] = tgt_addr[gi];
      end
    end
  endgenerate

  always_comb begin
    if (ret_flag)                  pick = PICK_RET;
    else if (jmp_flag)             pick = PICK_TGT;
    else if (br_flag && cond_hit)  pick = PICK_TGT;
    else                           pick = PICK_SEQ;
  end

  always_comb begin
    unique case (pick)
      PICK_RET: cand = saved_pc;
      PICK_TGT: cand = tgt_aligned;
      default:  cand = seq_pc;
    endcase
  end
endmodule

// File: rtl/bpc_irq_state.sv
module bpc_irq_state #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            exec_en,
  input  logic            irq_req,
  input  logic            ret_flag,
  input  logic [XLEN-1:0] cand,
  output logic            busy,
  output logic            accept,
  output logic [XLEN-1:0] saved_pc
);
  assign accept = irq_req && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
    end else if (exec_en) begin
      if (ret_flag)     busy <= 1'b0;
      else if (irq_req) busy <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      saved_pc <= '0;
    end else if (exec_en && accept) begin
      saved_pc <= cand;
    end
  end

  // R5: without enable the flag is frozen
  a_r5_flag_frozen: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> $stable(busy));
  // R5: return clears the flag
  a_r5_ret_clears: assert property (@(posedge clk) disable iff (rst)
    (exec_en && ret_flag) |=> !busy);
  // R5: request without return sets it
  a_r5_irq_sets: assert property (@(posedge clk) disable iff (rst)
    (exec_en && irq_req && !ret_flag) |=> busy);
  // R7: saved address changes only on an accepted, enabled interrupt
  a_r7_saved_hold: assert property (@(posedge clk) disable iff (rst)
    !(exec_en && irq_req && !busy) |=> $stable(saved_pc));
  // R7: saved address captures the candidate
  a_r7_saved_load: assert property (@(posedge clk) disable iff (rst)
    (exec_en && irq_req && !busy) |=> (saved_pc == $past(cand)));
endmodule

// File: rtl/bpc_unit.sv
module bpc_unit #(
  parameter int XLEN       = 32,
  parameter int ALIGN_BITS = 2,
  parameter int VEC_ADDR   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            exec_en,
  input  logic            irq_req,
  input  logic            br_flag,
  input  logic            jmp_flag,
  input  logic            ret_flag,
  input  logic [2:0]      cmp_code,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [XLEN-1:0] tgt_addr,
  input  logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] pc_next
);
  localparam logic [XLEN-1:0] VEC = XLEN'(VEC_ADDR);

  logic            cond_hit;
  logic            busy;
  logic            accept;
  logic [XLEN-1:0] saved_pc;
  logic [XLEN-1:0] cand;

  bpc_cond #(.XLEN(XLEN)) u_cond (
    .cmp_code (cmp_code),
    .op_a     (op_a),
    .op_b     (op_b),
    .hit      (cond_hit)
  );

  bpc_select #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS)) u_sel (
    .ret_flag (ret_flag),
    .jmp_flag (jmp_flag),
    .br_flag  (br_flag),
    .cond_hit (cond_hit),
    .saved_pc (saved_pc),
    .tgt_addr (tgt_addr),
    .seq_pc   (seq_pc),
    .cand     (cand)
  );

  bpc_irq_state #(.XLEN(XLEN)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .exec_en  (exec_en),
    .irq_req  (irq_req),
    .ret_flag (ret_flag),
    .cand     (cand),
    .busy     (busy),
    .accept   (accept),
    .saved_pc (saved_pc)
  );

  assign pc_next = accept ? VEC : cand;

  // R6: accepted interrupt yields the vector
  a_r6_vector: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !busy) |-> (pc_next == VEC));
  // R2: a jump with no interrupt leaves an aligned address
  a_r2_aligned: assert property (@(posedge clk) disable iff (rst)
    (jmp_flag && !ret_flag && !accept) |-> (pc_next[ALIGN_BITS-1:0] == '0));
  // R8: busy means the candidate passes through
  a_r8_masked: assert property (@(posedge clk) disable iff (rst)
    busy |-> (pc_next == cand));
  // R1: plain sequential flow when nothing else applies
  a_r1_seq: assert property (@(posedge clk) disable iff (rst)
    (!ret_flag && !jmp_flag && !br_flag && !accept) |-> (pc_next == seq_pc));
endmodule

// File: tb/bpc_unit_test.sv
module bpc_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, exec_en, irq_req, br_flag, jmp_flag, ret_flag;
  logic [2:0]  cmp_code;
  logic [31:0] op_a, op_b, tgt_addr, seq_pc, pc_next;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bpc_unit uut (
    .clk(clk), .rst(rst), .exec_en(exec_en), .irq_req(irq_req),
    .br_flag(br_flag), .jmp_flag(jmp_flag), .ret_flag(ret_flag),
    .cmp_code(cmp_code), .op_a(op_a), .op_b(op_b),
    .tgt_addr(tgt_addr), .seq_pc(seq_pc), .pc_next(pc_next)
  );

  task automatic check(input string req, input logic [31:0] exp);
    total++;
    if (pc_next !== exp) begin
      bad++;
      $display("FAIL %s: pc_next=%h expected=%h", req, pc_next, exp);
    end
  endtask

  task automatic drive(input logic en, input logic irq, input logic br,
                       input logic jmp, input logic ret, input logic [2:0] cc,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] t, input logic [31:0] s);
    @(negedge clk);
    exec_en = en; irq_req = irq; br_flag = br; jmp_flag = jmp; ret_flag = ret;
    cmp_code = cc; op_a = a; op_b = b; tgt_addr = t; seq_pc = s;
    #1;
  endtask

  function automatic bit model_hit(input logic [2:0] cc, input logic [31:0] a,
                                   input logic [31:0] b);
    case (cc)
      3'b000: return a == b;
      3'b001: return a != b;
      3'b100: return $signed(a) <  $signed(b);
      3'b101: return $signed(a) >= $signed(b);
      3'b110: return a <  b;
      3'b111: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  logic [31:0] vals [6];

  initial begin
    vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'h7fff_ffff;
    vals[3] = 32'h8000_0000; vals[4] = 32'hffff_ffff; vals[5] = 32'h5;
    rst = 1'b1;
    drive(0, 0, 0, 0, 0, 3'd0, 0, 0, 0, 32'h40);
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // reset state: saved address is 0, flag clear (R7, R5)
    drive(0, 0, 0, 0, 1, 3'd0, 0, 0, 32'h88, 32'h40);
    check("R7 reset saved", 32'h0);
    drive(0, 1, 0, 0, 0, 3'd0, 0, 0, 0, 32'h40);
    check("R5 reset flag clear", 32'h4);

    // R3 / R4 sweep: every code, every operand pair, branch on and off
    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++) begin
          drive(0, 0, 1, 0, 0, 3'(c), vals[i], vals[j], 32'h1237, 32'h200);
          check("R3 compare", model_hit(3'(c), vals[i], vals[j]) ? 32'h1234 : 32'h200);
          drive(0, 0, 0, 0, 0, 3'(c), vals[i], vals[j], 32'h1237, 32'h200);
          check("R4 not branch", 32'h200);
        end

    // R1 priority over all flag combinations, branch condition true (equal)
    for (int m = 0; m < 8; m++) begin
      logic [31:0] e;
      if (m[2])      e = 32'h0;
      else if (m[1]) e = 32'h3000;
      else if (m[0]) e = 32'h3000;
      else           e = 32'h500;
      drive(0, 0, m[0], m[1], m[2], 3'd0, 32'h9, 32'h9, 32'h3002, 32'h500);
      check("R1 priority", e);
    end
    // R2 target alignment for each low-bit pattern
    for (int k = 0; k < 4; k++) begin
      drive(0, 0, 0, 1, 0, 3'd0, 0, 0, 32'h7770 | 32'(k), 32'h500);
      check("R2 aligned", 32'h7770);
    end

    // interrupt entry with a jump candidate
    drive(1, 1, 0, 1, 0, 3'd0, 0, 0, 32'h1003, 32'h104);
    check("R6 vector", 32'h4);
    @(posedge clk);
    drive(1, 1, 0, 0, 0, 3'd0, 0, 0, 0, 32'h8);
    check("R8 busy ignores irq", 32'h8);
    @(posedge clk);
    drive(0, 1, 0, 0, 1, 3'd0, 0, 0, 0, 32'h8);
    check("R7 saved jump target", 32'h1000);
    @(posedge clk);
    // flag still set because enable was low
    drive(0, 1, 0, 0, 0, 3'd0, 0, 0, 0, 32'h10);
    check("R5 no change without enable", 32'h10);
    drive(1, 0, 0, 0, 1, 3'd0, 0, 0, 0, 32'h10);
    check("R7 return address", 32'h1000);
    @(posedge clk);
    // flag now clear; request without enable is accepted but saves nothing
    drive(0, 1, 0, 0, 0, 3'd0, 0, 0, 0, 32'h200);
    check("R6 accept after return", 32'h4);
    @(posedge clk);
    drive(0, 0, 0, 0, 1, 3'd0, 0, 0, 0, 32'h200);
    check("R7 hold without enable", 32'h1000);
    // enabled cycle with no request holds the clear flag
    drive(1, 0, 0, 0, 0, 3'd0, 0, 0, 0, 32'h20);
    check("R5 hold", 32'h20);
    @(posedge clk);
    drive(0, 1, 0, 0, 0, 3'd0, 0, 0, 0, 32'h20);
    check("R5 still clear", 32'h4);
    // return and request together: vector, saved keeps its value, flag cleared
    drive(1, 1, 0, 0, 1, 3'd0, 0, 0, 0, 32'h20);
    check("R6 with return", 32'h4);
    @(posedge clk);
    drive(0, 1, 0, 0, 0, 3'd0, 0, 0, 0, 32'h24);
    check("R5 return wins", 32'h4);
    drive(0, 0, 0, 0, 1, 3'd0, 0, 0, 0, 32'h24);
    check("R7 reload of same", 32'h1000);
    // taken branch saved as candidate
    drive(1, 1, 1, 0, 0, 3'b110, 32'h1, 32'h2, 32'h2222, 32'h30);
    check("R6 over branch", 32'h4);
    @(posedge clk);
    drive(0, 0, 0, 0, 1, 3'd0, 0, 0, 0, 32'h30);
    check("R7 saved branch target", 32'h2220);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: pc_next=%h expected=completion", pc_next);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule